// File: doc/BRIEF.md
# Ternary Logic and Bit-Permute Unit

A combinational bit-manipulation unit for a 64-bit datapath. It carries out one of two operations in a single pass. The first is a bitwise three-input logic function. For every bit position, the three operand bits at that position form a 3-bit selector. That selector picks one bit of an 8-bit truth-table immediate. Any function of three inputs can therefore be produced with one operation.

The second operation is a generalized bit reverse. Output bit i is taken from data bit (i XOR k), where k is the low part of a control operand. In 32-bit mode only the lower half is permuted, and the upper half of the result is cleared. Instruction decode, operand fetch and result write-back sit in the surrounding pipeline.

Top module: `bitmanip_unit`

## Requirements
- R1: With op_sel_i = 2'b01 (ternary), each result bit i equals tt_imm_i[{src_b_i[i], src_a_i[i], src_c_i[i]}]. Operand B is the MSB of the index, A the middle bit and C the LSB. Every bit position is independent of the others.
- R2: In ternary mode, an immediate of 8'hF0 returns src_b_i, 8'hCC returns src_a_i and 8'hAA returns src_c_i. An immediate of 8'hFF returns all ones and 8'h00 returns all zeros.
- R3: In ternary mode, half_mode_i has no effect: all 64 bits are computed in both settings.
- R4: With op_sel_i = 2'b10 (permute) and half_mode_i = 0, result bit i equals src_a_i[i XOR src_b_i[5:0]]. Bits 63:6 of src_b_i have no effect.
- R5: With op_sel_i = 2'b10 and half_mode_i = 1, result bit i equals src_a_i[i XOR src_b_i[4:0]] for i in 0..31, and result bits 63:32 are zero. Bit 5 of src_b_i has no effect.
- R6: In permute mode, a control of zero (src_b_i[5:0] = 0 in full mode, src_b_i[4:0] = 0 in half mode) returns the data unchanged within the active width.
- R7: In permute mode, a control of all ones reverses the bit order within the active width. In full mode bit i takes bit 63-i; in half mode bit i takes bit 31-i for i below 32.
- R8: valid_o is 1 exactly when op_sel_i is 2'b01 or 2'b10. For op_sel_i 2'b00 or 2'b11, valid_o is 0 and result_o is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a_i | input | 64 | Operand A: ternary middle index bit; permute data |
| src_b_i | input | 64 | Operand B: ternary index MSB; permute control in the low bits |
| src_c_i | input | 64 | Operand C: ternary index LSB |
| tt_imm_i | input | 8 | Truth table for the ternary operation |
| op_sel_i | input | 2 | 01 ternary, 10 permute, 00/11 no operation |
| half_mode_i | input | 1 | 32-bit mode for the permute |
| result_o | output | 64 | Operation result |
| valid_o | output | 1 | High when a supported operation is selected |

## Verification
The ternary path is tested with random operands and immediates. It is also tested with the projection immediates (F0, CC, AA) and the constant immediates (FF, 00). The projections separate the roles of the three operands, so a swapped index order shows up as the wrong operand at the output. The permute is tested with random controls in both widths. Controls of zero and all ones, and controls whose ignored high bits are set, show whether the identity case, the full reversal and the masking of the control width are right. Patterns whose lower and upper halves differ show any leakage into the cleared upper half in 32-bit mode. The two undefined operation codes are applied to show that nothing reaches the result.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_TERN = 2'b01,
    OP_PERM = 2'b10,
    OP_RSVD = 2'b11
  } bm_op_e;
endpackage

// File: rtl/tern_lut.sv
module tern_lut #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic [7:0]   imm_i,
  output logic [W-1:0] res_o
);
  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    // index order: b is MSB, a middle, c LSB
    assign res_o[gi] = imm_i[{b_i[gi], a_i[gi], c_i[gi]}];
  end
endmodule

// File: rtl/xor_permute.sv
module xor_permute #(
  parameter int unsigned W = 64,
  localparam int unsigned IDX_W = $clog2(W),
  localparam int unsigned HALF = W / 2
) (
  input  logic [W-1:0]     data_i,
  input  logic [IDX_W-1:0] ctl_i,
  input  logic             half_i,
  output logic [W-1:0]     perm_o
);
  logic [W-1:0] full_w;
  logic [W-1:0] half_w;

  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    logic [IDX_W-1:0] fidx;
    assign fidx       = IDX_W'(gi) ^ ctl_i;
    assign full_w[gi] = data_i[fidx];
    if (gi < HALF) begin : g_lo
      logic [IDX_W-2:0] hidx;
      assign hidx       = (IDX_W-1)'(gi) ^ ctl_i[IDX_W-2:0];
      assign half_w[gi] = data_i[hidx];
    end else begin : g_hi
      assign half_w[gi] = 1'b0;
    end
  end

  assign perm_o = half_i ? half_w : full_w;
endmodule

// File: rtl/bitmanip_unit.sv
module bitmanip_unit
  import bm_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [DATA_W-1:0] src_c_i,
  input  logic [7:0]        tt_imm_i,
  input  logic [1:0]        op_sel_i,
  input  logic              half_mode_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o
);
  bm_op_e            op_e;
  logic [DATA_W-1:0] tern_res;
  logic [DATA_W-1:0] perm_res;

  assign op_e = bm_op_e'(op_sel_i);

  tern_lut #(.W(DATA_W)) u_tern (
    .a_i  (src_a_i),
    .b_i  (src_b_i),
    .c_i  (src_c_i),
    .imm_i(tt_imm_i),
    .res_o(tern_res)
  );

  xor_permute #(.W(DATA_W)) u_perm (
    .data_i(src_a_i),
    .ctl_i (src_b_i[IDX_W-1:0]),
    .half_i(half_mode_i),
    .perm_o(perm_res)
  );

  always_comb begin
    result_o = '0;
    valid_o  = 1'b0;
    unique case (op_e)
      OP_TERN: begin
        result_o = tern_res;
        valid_o  = 1'b1;
      end
      OP_PERM: begin
        result_o = perm_res;
        valid_o  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bitmanip_unit_chk.sv
module bitmanip_unit_chk #(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned HALF = DATA_W / 2
) (
  input logic [DATA_W-1:0] src_a_i,
  input logic [DATA_W-1:0] src_b_i,
  input logic [DATA_W-1:0] src_c_i,
  input logic [7:0]        tt_imm_i,
  input logic [1:0]        op_sel_i,
  input logic              half_mode_i,
  input logic [DATA_W-1:0] result_o,
  input logic              valid_o
);
  logic is_tern, is_perm;
  assign is_tern = (op_sel_i == 2'b01);
  assign is_perm = (op_sel_i == 2'b10);

  always_comb begin
    if (is_tern && tt_imm_i == 8'hF0) AST_TT_COPY_B: assert (result_o == src_b_i); // R2
    if (is_tern && tt_imm_i == 8'hCC) AST_TT_COPY_A: assert (result_o == src_a_i); // R2
    if (is_tern && tt_imm_i == 8'hAA) AST_TT_COPY_C: assert (result_o == src_c_i); // R2
    if (is_tern && tt_imm_i == 8'hFF) AST_TT_ONES: assert (&result_o); // R1
    if (is_tern && tt_imm_i == 8'h00) AST_TT_ZEROS: assert (result_o == '0); // R1
    if (is_perm && half_mode_i) AST_HALF_UPPER_ZERO: assert (result_o[DATA_W-1:HALF] == '0); // R5
    if (is_perm && !half_mode_i && src_b_i[5:0] == 6'd0) AST_PERM_ID_FULL: assert (result_o == src_a_i); // R6
    if (is_perm && half_mode_i && src_b_i[4:0] == 5'd0)
      AST_PERM_ID_HALF: assert (result_o[HALF-1:0] == src_a_i[HALF-1:0]); // R6
    AST_VALID_DECODE: assert (valid_o == (is_tern || is_perm)); // R8
    if (!valid_o) AST_IDLE_ZERO: assert (result_o == '0); // R8
  end
endmodule

bind bitmanip_unit bitmanip_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .src_a_i    (src_a_i),
  .src_b_i    (src_b_i),
  .src_c_i    (src_c_i),
  .tt_imm_i   (tt_imm_i),
  .op_sel_i   (op_sel_i),
  .half_mode_i(half_mode_i),
  .result_o   (result_o),
  .valid_o    (valid_o)
);

// File: tb/bitmanip_unit_bench.sv
`timescale 1ns/1ps
module bitmanip_unit_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [63:0] a, b, c, res;
  logic [7:0]  imm;
  logic [1:0]  op;
  logic        half, vld;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  bitmanip_unit u_bitmanip_unit (
    .src_a_i(a), .src_b_i(b), .src_c_i(c), .tt_imm_i(imm),
    .op_sel_i(op), .half_mode_i(half), .result_o(res), .valid_o(vld)
  );

  localparam int NV = 8;
  localparam logic [63:0] V_A [NV] = '{64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000,
    64'hDEAD_BEEF_CAFE_F00D, 64'h8000_0000_0000_0001, 64'h0123_4567_89AB_CDEF,
    64'hA5A5_5A5A_0F0F_F0F0, 64'h8000_0000_0000_0001, 64'h1357_9BDF_2468_ACE0};
  localparam logic [63:0] V_B [NV] = '{64'hF0F0_F0F0_F0F0_F0F0, 64'h00FF_00FF_00FF_00FF,
    64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0015,
    64'hFFFF_FFFF_FFFF_FFC0, 64'h0000_0000_0000_003F, 64'h0000_0000_0000_0021};
  localparam logic [63:0] V_C [NV] = '{64'hCCCC_CCCC_CCCC_CCCC, 64'h0F0F_0F0F_0F0F_0F0F,
    64'h5555_AAAA_5555_AAAA, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 64'h0, 64'h0};
  localparam logic [7:0] V_IMM [NV] = '{8'hE8, 8'h96, 8'h1B, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00};
  localparam logic [1:0] V_OP  [NV] = '{2'b01, 2'b01, 2'b01, 2'b01, 2'b10, 2'b10, 2'b10, 2'b10};
  localparam logic       V_HF  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};

  // sum of minterms, independent of the index form
  function automatic logic [63:0] m_tern(logic [63:0] x, logic [63:0] y, logic [63:0] z, logic [7:0] t);
    logic [63:0] r = '0;
    for (int k = 0; k < 8; k++)
      if (t[k]) r |= (k[2] ? y : ~y) & (k[1] ? x : ~x) & (k[0] ? z : ~z);
    return r;
  endfunction

  function automatic logic [63:0] m_perm(logic [63:0] x, logic [63:0] ctl, logic h);
    logic [63:0] r = '0;
    for (int i = 0; i < 64; i++) begin
      if (h) begin
        if (i < 32) r[i] = x[i ^ int'(ctl[4:0])];
      end else r[i] = x[i ^ int'(ctl[5:0])];
    end
    return r;
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic apply(logic [63:0] na, logic [63:0] nb, logic [63:0] nc, logic [7:0] ni, logic [1:0] no, logic nh);
    @(negedge clk);
    a = na; b = nb; c = nc; imm = ni; op = no; half = nh;
    #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog all-reqs actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [63:0] ra, rb, rc, rev, r0, r1;
    logic [7:0] ri;
    // idle state
    apply('0, '0, '0, 8'h00, 2'b00, 1'b0);
    check("R8 idle valid", {63'd0, vld}, 64'd0);
    check("R8 idle result", res, 64'd0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      apply(V_A[v], V_B[v], V_C[v], V_IMM[v], V_OP[v], V_HF[v]);
      if (V_OP[v] == 2'b01) check("R1 table tern", res, m_tern(V_A[v], V_B[v], V_C[v], V_IMM[v]));
      else if (V_HF[v]) check("R5 table perm32", res, m_perm(V_A[v], V_B[v], 1'b1));
      else check("R4 table perm64", res, m_perm(V_A[v], V_B[v], 1'b0));
      check("R8 table valid", {63'd0, vld}, 64'd1);
    end

    // random ternary, both widths
    for (int n = 0; n < 200; n++) begin
      ra = {$urandom, $urandom}; rb = {$urandom, $urandom}; rc = {$urandom, $urandom};
      ri = 8'($urandom);
      apply(ra, rb, rc, ri, 2'b01, 1'b0);
      r0 = res;
      check("R1 rand tern", res, m_tern(ra, rb, rc, ri));
      apply(ra, rb, rc, ri, 2'b01, 1'b1);
      check("R3 tern half ignored", res, r0);
    end

    // projections and constants
    ra = 64'h0123_4567_89AB_CDEF; rb = 64'hFEDC_BA98_7654_3210; rc = 64'h5A5A_A5A5_3C3C_C3C3;
    apply(ra, rb, rc, 8'hF0, 2'b01, 1'b0); check("R2 imm F0 -> B", res, rb);
    apply(ra, rb, rc, 8'hCC, 2'b01, 1'b0); check("R2 imm CC -> A", res, ra);
    apply(ra, rb, rc, 8'hAA, 2'b01, 1'b1); check("R2 imm AA -> C", res, rc);
    apply(ra, rb, rc, 8'hFF, 2'b01, 1'b1); check("R2 imm FF ones", res, '1);
    apply(ra, rb, rc, 8'h00, 2'b01, 1'b0); check("R2 imm 00 zeros", res, '0);

    // random permute
    for (int n = 0; n < 200; n++) begin
      ra = {$urandom, $urandom}; rb = {$urandom, $urandom};
      apply(ra, rb, '0, 8'h00, 2'b10, 1'b0);
      check("R4 rand perm64", res, m_perm(ra, rb, 1'b0));
      apply(ra, rb, '0, 8'h00, 2'b10, 1'b1);
      check("R5 rand perm32", res, m_perm(ra, rb, 1'b1));
    end

    // ignored control bits
    ra = 64'hDEAD_BEEF_0BAD_F00D;
    apply(ra, 64'h0000_0000_0000_0009, '0, 8'h00, 2'b10, 1'b0); r0 = res;
    apply(ra, 64'hFFFF_FFFF_FFFF_FFC9, '0, 8'h00, 2'b10, 1'b0);
    check("R4 high ctl bits ignored", res, r0);
    apply(ra, 64'h0000_0000_0000_0009, '0, 8'h00, 2'b10, 1'b1); r1 = res;
    apply(ra, 64'h0000_0000_0000_0029, '0, 8'h00, 2'b10, 1'b1);
    check("R5 ctl bit5 ignored", res, r1);
    check("R5 upper zero", {32'd0, res[63:32]}, 64'd0);

    // identity
    apply(ra, 64'hFFFF_FFFF_FFFF_FFC0, '0, 8'h00, 2'b10, 1'b0); check("R6 ctl0 identity64", res, ra);
    apply(ra, 64'h0000_0000_0000_0020, '0, 8'h00, 2'b10, 1'b1); check("R6 ctl0 identity32", res, {32'd0, ra[31:0]});

    // reversal
    for (int i = 0; i < 64; i++) rev[i] = ra[63-i];
    apply(ra, 64'h3F, '0, 8'h00, 2'b10, 1'b0); check("R7 reverse64", res, rev);
    rev = '0;
    for (int i = 0; i < 32; i++) rev[i] = ra[31-i];
    apply(ra, 64'h1F, '0, 8'h00, 2'b10, 1'b1); check("R7 reverse32", res, rev);

    // undefined codes
    apply(ra, 64'h3F, 64'h1, 8'hFF, 2'b11, 1'b0);
    check("R8 op11 valid", {63'd0, vld}, 64'd0);
    check("R8 op11 result", res, 64'd0);
    apply(ra, 64'h3F, 64'h1, 8'hFF, 2'b00, 1'b1);
    check("R8 op00 valid", {63'd0, vld}, 64'd0);
    check("R8 op00 result", res, 64'd0);
    apply(ra, 64'h3F, 64'h1, 8'hFF, 2'b10, 1'b1);
    check("R8 perm valid", {63'd0, vld}, 64'd1);

    done = 1'b1;
    finish_run();
  end
endmodule